// File: doc/BRIEF.md
# Conversion Start Strobe Scheduler

This block drives the start strobe of an external sampling converter from a system clock. The strobe also serves as a status line. A rising edge begins a conversion. The moment the conversion result becomes ready is reported as a one-cycle done pulse and as an active-low interrupt level that falls at that moment. A read-permit output tells the host when a serial read or write of the converter may run. It stays low for a fixed guard window at the end of every period, so no bus traffic overlaps the next rising edge.

Two strobe shapes are available. In square mode the strobe stays high for the programmed high time, and its falling edge marks data ready. In pulse mode a short strobe is issued, and data ready is declared a fixed conversion time after the rising edge. High, low and pulse durations come in as cycle counts. They are clamped so that the conversion always fits and a read window of at least one cycle always exists. They are sampled only when a period starts. If the host reports a transfer still busy inside the guard window, a sticky violation flag is raised, and the host can clear it.

Top module: `cnvst_sched`

## Requirements
- R1: While reset is held and afterwards until the first enable, the outputs are idle: strobe 0, conv_done 0, irq_n 1, read_ok 0, guard_viol 0.
- R2: When enable is first sampled high at a clock edge, strobe is high in the cycle after that edge. That cycle is tick 0 of a period. In square mode (mode_pulse = 0) strobe stays high for max(high_cyc, CONV_CYC) cycles.
- R3: The low part of a period lasts max(low_cyc, GUARD_CYC + 1) cycles. The period equals the ready point plus this low time, and the next rising edge of strobe falls exactly one period after the previous one.
- R4: In pulse mode (mode_pulse = 1), strobe is high for pulse_cyc clamped to the range 1..CONV_CYC. The ready point is CONV_CYC. high_cyc has no effect.
- R5: conv_done is high for exactly one cycle, at the ready point: the tick equal to the square-mode high time, or CONV_CYC in pulse mode. irq_n is low from the ready point up to and including the last tick of the period.
- R6: The guard window is the last GUARD_CYC cycles of every period. read_ok is high exactly from the ready point up to the cycle before the guard window.
- R7: A host_busy sampled high at an edge that ends a guard-window cycle sets guard_viol in the next cycle. A host_busy that is high only outside the guard window leaves guard_viol at 0.
- R8: guard_viol holds until viol_clr is sampled high, and then reads 0 in the next cycle. If a new violation arrives in the same cycle as the clear, the set wins.
- R9: Changes to mode_pulse, high_cyc, low_cyc and pulse_cyc during a period take effect only at the start of the next period.
- R10: When enable is sampled low, strobe, conv_done and read_ok are 0 and irq_n is 1 in the following cycle. The next enable starts a fresh period at tick 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the strobe schedule |
| mode_pulse | input | 1 | 0 = square strobe, 1 = narrow pulse strobe |
| high_cyc | input | DUR_W | Square-mode high time in cycles |
| low_cyc | input | DUR_W | Low time after the ready point in cycles |
| pulse_cyc | input | DUR_W | Pulse-mode strobe width in cycles |
| host_busy | input | 1 | Host serial transfer in progress |
| viol_clr | input | 1 | Clear the sticky violation flag |
| strobe | output | 1 | Conversion start strobe to the converter |
| conv_done | output | 1 | One-cycle pulse at the ready point |
| irq_n | output | 1 | Active-low data-ready interrupt level |
| read_ok | output | 1 | Host transfer permitted |
| guard_viol | output | 1 | Sticky guard-window violation flag |

## Verification
Strobe, conv_done, irq_n and read_ok are decoded from the registered phase counter. Each takes its new value in the cycle right after the edge that moved the counter, and tick 0 is the cycle after enable is first sampled high. guard_viol is a register and shows a violation one cycle after the edge that sampled host_busy inside the guard window. A clear also takes effect one cycle after the edge that sampled it. The bench drives every input on the falling clock edge and reads outputs on the following falling edges, and it numbers these cycles from tick 0. Expected values come from the tick number and the clamped durations the requirements give, including the cycle before the guard opens and the first guard cycle.

// File: rtl/cnvst_pkg.sv
package cnvst_pkg;

  typedef enum logic {
    MODE_SQUARE = 1'b0,
    MODE_PULSE  = 1'b1
  } cnv_mode_e;

  // Clamp v into [lo, hi]
  function automatic int unsigned clamp_u(int unsigned v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Ready point: tick at which the conversion result is declared available
  function automatic int unsigned ready_point(cnv_mode_e m, int unsigned hi_e, int unsigned conv);
    return (m == MODE_PULSE) ? conv : hi_e;
  endfunction

  // Number of cycles the strobe stays high
  function automatic int unsigned strobe_span(cnv_mode_e m, int unsigned hi_e, int unsigned pw_e);
    return (m == MODE_PULSE) ? pw_e : hi_e;
  endfunction

endpackage

// File: rtl/cnvst_cfg_latch.sv
module cnvst_cfg_latch
  import cnvst_pkg::*;
#(
  parameter int unsigned DUR_W     = 16,
  parameter int unsigned CONV_CYC  = 295,
  parameter int unsigned GUARD_CYC = 25,
  localparam int unsigned CW       = DUR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  cnv_mode_e        mode,
  input  logic [DUR_W-1:0] high_cyc,
  input  logic [DUR_W-1:0] low_cyc,
  input  logic [DUR_W-1:0] pulse_cyc,
  output logic [CW-1:0]    strobe_len,
  output logic [CW-1:0]    ready_at,
  output logic [CW-1:0]    last_tick,
  output logic [CW-1:0]    guard_at
);

  localparam int unsigned DMAX = (1 << DUR_W) - 1;

  int unsigned hi_e, lo_e, pw_e, rdy, span, per;

  always_comb begin
    hi_e = clamp_u(int'(high_cyc),  CONV_CYC,      DMAX);
    lo_e = clamp_u(int'(low_cyc),   GUARD_CYC + 1, DMAX);
    pw_e = clamp_u(int'(pulse_cyc), 1,             CONV_CYC);
    rdy  = ready_point(mode, hi_e, CONV_CYC);
    span = strobe_span(mode, hi_e, pw_e);
    per  = rdy + lo_e;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_len <= '0;
      ready_at   <= '0;
      last_tick  <= '0;
      guard_at   <= '0;
    end else if (load) begin
      strobe_len <= CW'(span);
      ready_at   <= CW'(rdy);
      last_tick  <= CW'(per - 1);
      guard_at   <= CW'(per - GUARD_CYC);
    end
  end

endmodule

// File: rtl/cnvst_phase_ctr.sv
module cnvst_phase_ctr #(
  parameter int unsigned CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [CW-1:0] last_tick,
  output logic          run,
  output logic [CW-1:0] tick,
  output logic          wrap,
  output logic          period_start
);

  assign wrap         = run && (tick == last_tick);
  assign period_start = run && (tick == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      tick <= '0;
    end else begin
      run <= enable;
      if (!enable || !run || wrap) tick <= '0;
      else                         tick <= tick + 1'b1;
    end
  end

endmodule

// File: rtl/cnvst_decode.sv
module cnvst_decode #(
  parameter int unsigned CW = 17
) (
  input  logic          run,
  input  logic [CW-1:0] tick,
  input  logic [CW-1:0] strobe_len,
  input  logic [CW-1:0] ready_at,
  input  logic [CW-1:0] guard_at,
  output logic          strobe,
  output logic          ready_evt,
  output logic          irq_n,
  output logic          guard_win,
  output logic          read_ok
);

  logic past_ready;

  assign past_ready = run && (tick >= ready_at);
  assign strobe     = run && (tick < strobe_len);
  assign ready_evt  = run && (tick == ready_at);
  assign irq_n      = !past_ready;
  assign guard_win  = run && (tick >= guard_at);
  assign read_ok    = past_ready && !guard_win;

endmodule

// File: rtl/cnvst_guard_mon.sv
module cnvst_guard_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic guard_win,
  input  logic host_busy,
  input  logic viol_clr,
  output logic viol
);

  logic hit;
  assign hit = guard_win && host_busy;

  always_ff @(posedge clk) begin
    if (!rst_n)        viol <= 1'b0;
    else if (hit)      viol <= 1'b1;
    else if (viol_clr) viol <= 1'b0;
  end

endmodule

// File: rtl/cnvst_sched.sv
module cnvst_sched
  import cnvst_pkg::*;
#(
  parameter int unsigned DUR_W     = 16,
  parameter int unsigned CONV_CYC  = 295,
  parameter int unsigned GUARD_CYC = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mode_pulse,
  input  logic [DUR_W-1:0] high_cyc,
  input  logic [DUR_W-1:0] low_cyc,
  input  logic [DUR_W-1:0] pulse_cyc,
  input  logic             host_busy,
  input  logic             viol_clr,
  output logic             strobe,
  output logic             conv_done,
  output logic             irq_n,
  output logic             read_ok,
  output logic             guard_viol
);

  localparam int unsigned CW = DUR_W + 1;

  logic [CW-1:0] strobe_len, ready_at, last_tick, guard_at, tick;
  logic          run, wrap, period_start, guard_win, ready_evt, cfg_load;
  cnv_mode_e     mode;

  assign mode     = cnv_mode_e'(mode_pulse);
  assign cfg_load = !run || wrap;

  cnvst_cfg_latch #(
    .DUR_W(DUR_W), .CONV_CYC(CONV_CYC), .GUARD_CYC(GUARD_CYC)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .mode(mode),
    .high_cyc(high_cyc), .low_cyc(low_cyc), .pulse_cyc(pulse_cyc),
    .strobe_len(strobe_len), .ready_at(ready_at),
    .last_tick(last_tick), .guard_at(guard_at)
  );

  cnvst_phase_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .enable(enable), .last_tick(last_tick),
    .run(run), .tick(tick), .wrap(wrap), .period_start(period_start)
  );

  cnvst_decode #(.CW(CW)) u_dec (
    .run(run), .tick(tick), .strobe_len(strobe_len), .ready_at(ready_at),
    .guard_at(guard_at), .strobe(strobe), .ready_evt(ready_evt),
    .irq_n(irq_n), .guard_win(guard_win), .read_ok(read_ok)
  );

  cnvst_guard_mon u_mon (
    .clk(clk), .rst_n(rst_n), .guard_win(guard_win), .host_busy(host_busy),
    .viol_clr(viol_clr), .viol(guard_viol)
  );

  assign conv_done = ready_evt;

endmodule

// File: rtl/cnvst_sched_chk.sv
module cnvst_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic host_busy,
  input logic viol_clr,
  input logic strobe,
  input logic conv_done,
  input logic irq_n,
  input logic read_ok,
  input logic guard_viol,
  input logic guard_win,
  input logic period_start
);

  assert_idle_after_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!strobe && !conv_done && !read_ok && irq_n));

  assert_rise_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> period_start);

  assert_done_irq_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> !irq_n);

  assert_no_read_in_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    guard_win |-> !read_ok);

  assert_read_strobe_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |-> (!strobe && !irq_n));

  assert_viol_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_win && host_busy) |=> guard_viol);

  assert_viol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_viol && !viol_clr) |=> guard_viol);

  assert_viol_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_clr && !(guard_win && host_busy)) |=> !guard_viol);

endmodule

bind cnvst_sched cnvst_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .host_busy(host_busy),
  .viol_clr(viol_clr), .strobe(strobe), .conv_done(conv_done), .irq_n(irq_n),
  .read_ok(read_ok), .guard_viol(guard_viol), .guard_win(guard_win),
  .period_start(period_start)
);

// File: tb/tb_cnvst_sched.sv
module tb_cnvst_sched;

  localparam int DW    = 16;
  localparam int CONV  = 295;
  localparam int GUARD = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, mode_pulse = 1'b0, host_busy = 1'b0, viol_clr = 1'b0;
  logic [DW-1:0] high_cyc = '0, low_cyc = '0, pulse_cyc = '0;
  logic strobe, conv_done, irq_n, read_ok, guard_viol;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #10ns clk = ~clk;

  cnvst_sched #(.DUR_W(DW), .CONV_CYC(CONV), .GUARD_CYC(GUARD)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_pulse(mode_pulse),
    .high_cyc(high_cyc), .low_cyc(low_cyc), .pulse_cyc(pulse_cyc),
    .host_busy(host_busy), .viol_clr(viol_clr), .strobe(strobe),
    .conv_done(conv_done), .irq_n(irq_n), .read_ok(read_ok),
    .guard_viol(guard_viol)
  );

  typedef struct packed {
    logic          mode;
    logic [15:0]   hi, lo, pw;
    logic [15:0]   slen, rdy, per;
  } vec_t;

  // stimulus (mode, high, low, pulse) and expected (strobe span, ready tick, period)
  localparam vec_t VECS [5] = '{
    {1'b0, 16'd295, 16'd295, 16'd0,   16'd295, 16'd295, 16'd590},
    {1'b0, 16'd400, 16'd60,  16'd0,   16'd400, 16'd400, 16'd460},
    {1'b0, 16'd10,  16'd5,   16'd0,   16'd295, 16'd295, 16'd321},
    {1'b1, 16'd999, 16'd100, 16'd4,   16'd4,   16'd295, 16'd395},
    {1'b1, 16'd3,   16'd0,   16'd0,   16'd1,   16'd295, 16'd321}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go(input int target);
    while (cyc < target) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic start(input logic m, input int hi, input int lo, input int pw);
    @(negedge clk);
    mode_pulse = m; high_cyc = DW'(hi); low_cyc = DW'(lo); pulse_cyc = DW'(pw);
    enable = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cyc = 0;
  endtask

  task automatic stop_and_check_idle();
    enable = 1'b0;
    @(negedge clk);
    chk(!strobe && !conv_done && !read_ok && irq_n, "R10 idle after disable",
        {strobe, conv_done, read_ok, irq_n}, 4'b0001);
  endtask

  initial begin
    #(200000 * 20ns);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int e_s, e_d, e_i, e_r;
    repeat (3) @(negedge clk);
    chk(!strobe && !conv_done && irq_n && !read_ok && !guard_viol, "R1 outputs during reset",
        {strobe, conv_done, irq_n, read_ok, guard_viol}, 5'b00100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!strobe && !conv_done && irq_n && !read_ok && !guard_viol, "R1 outputs after reset",
        {strobe, conv_done, irq_n, read_ok, guard_viol}, 5'b00100);

    // table walk: R2 R3 R4 R5 R6 over two full periods each
    for (int v = 0; v < 5; v++) begin
      vec_t t;
      t = VECS[v];
      e_s = 0; e_d = 0; e_i = 0; e_r = 0;
      start(t.mode, int'(t.hi), int'(t.lo), int'(t.pw));
      for (int c = 0; c < 2 * int'(t.per); c++) begin
        int ph;
        ph = c % int'(t.per);
        if (strobe    !== (ph < int'(t.slen)))  e_s++;
        if (conv_done !== (ph == int'(t.rdy)))  e_d++;
        if (irq_n     !== (ph < int'(t.rdy)))   e_i++;
        if (read_ok   !== (ph >= int'(t.rdy) && ph < int'(t.per) - GUARD)) e_r++;
        @(negedge clk);
      end
      chk(strobe == 1'b1, "R3 strobe rises again after two periods", strobe, 1);
      chk(e_s == 0, t.mode ? "R4 pulse strobe mismatches" : "R2 R3 square strobe mismatches", e_s, 0);
      chk(e_d == 0, "R5 conv_done mismatches", e_d, 0);
      chk(e_i == 0, "R5 irq_n mismatches", e_i, 0);
      chk(e_r == 0, "R6 read_ok mismatches", e_r, 0);
      stop_and_check_idle();
    end

    // R9: mid-period change waits for period start
    start(1'b0, 295, 295, 0);
    go(100);
    high_cyc = 16'd400; low_cyc = 16'd60;
    go(295);  chk(strobe == 1'b0, "R9 old high time kept", strobe, 0);
    go(589);  chk(strobe == 1'b0, "R9 old low time kept", strobe, 0);
    go(590);  chk(strobe == 1'b1, "R9 next period starts on old period", strobe, 1);
    go(989);  chk(strobe == 1'b1, "R9 new high time in force", strobe, 1);
    go(990);  chk(strobe == 1'b0 && conv_done, "R9 new ready point", {strobe, conv_done}, 2'b01);
    go(1049); chk(strobe == 1'b0, "R9 new low time", strobe, 0);
    go(1050); chk(strobe == 1'b1, "R9 new period length", strobe, 1);
    stop_and_check_idle();

    // R7 / R8: guard window violations (square 295/295, guard ticks 565..589)
    start(1'b0, 295, 295, 0);
    go(300); host_busy = 1'b1;
    go(310); host_busy = 1'b0;
    go(311); chk(guard_viol == 1'b0, "R7 busy in read window ignored", guard_viol, 0);
    go(564); host_busy = 1'b1;
    go(565); host_busy = 1'b0;
    chk(guard_viol == 1'b0, "R7 busy one cycle before guard ignored", guard_viol, 0);
    chk(read_ok == 1'b0, "R6 read_ok low at first guard tick", read_ok, 0);
    host_busy = 1'b1;
    go(566); host_busy = 1'b0;
    chk(guard_viol == 1'b1, "R7 busy at first guard tick sets flag", guard_viol, 1);
    go(600); chk(guard_viol == 1'b1, "R8 flag sticky into next period", guard_viol, 1);
    viol_clr = 1'b1;
    go(601); viol_clr = 1'b0;
    chk(guard_viol == 1'b0, "R8 clear takes effect", guard_viol, 0);
    go(1155); host_busy = 1'b1; viol_clr = 1'b1;
    go(1156); host_busy = 1'b0;
    chk(guard_viol == 1'b1, "R8 set wins over clear", guard_viol, 1);
    go(1157); viol_clr = 1'b0;
    chk(guard_viol == 1'b0, "R8 clear after set", guard_viol, 0);
    stop_and_check_idle();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule